// File: doc/BRIEF.md
# Four-Lane Column Alignment Monitor

This block sits behind the per-lane deskew buffers of a four-lane receive path and decides whether the lanes are lined up on a common column. Every cycle it receives one flag per lane that says the lane carries an alignment character, and one flag that marks the slot in the inter-packet gap where an alignment column is expected. It drives three things. The first is a column-aligned status bit for a management register to read. The second is a realignment-enable strobe that lets the external elastic buffers move their read pointers. The third is an override that swaps the receive data bus for a local-fault sequence while the lanes are not aligned.

Acquisition runs through an unaligned state and three detection states. Each step requires one more full alignment column, and any partial column sends the machine back to the start. Once aligned, the machine only looks at columns in the expected gap slot. A partial column there starts a three-step failure count. Each missing column advances the count and each good column steps it back by one.

Top module: `col_deskew_sm`

## Requirements
- R1: While rst_n is low at a rising clock edge, the machine enters the unaligned state: col_aligned is 0, realign_en is 1 and the local-fault override is active.
- R2: In the unaligned state, a complete column (all four lane flags high) moves the machine to the first detection state. Any other column keeps it unaligned. expect_pos is ignored.
- R3: Starting from the unaligned state, four complete columns, not necessarily in adjacent cycles, are needed to reach the aligned state. They pass through three detection states. Cycles with no lane flag set hold the current state.
- R4: In any detection state, a partial column (some but not all lane flags high) returns the machine to the unaligned state at the next edge, whatever the value of expect_pos.
- R5: col_aligned is 0 in the unaligned and detection states. It is 1 in the aligned state and in the three failure states.
- R6: realign_en is 1 only in the unaligned state. It is 0 in every detection, aligned and failure state.
- R7: In the aligned state, a partial column with expect_pos high moves the machine to the first failure state. A complete or empty column with expect_pos high, or any column with expect_pos low, leaves it aligned.
- R8: In a failure state with expect_pos high, a column that is not complete advances the machine one step (first to second, second to third, third to unaligned). A complete column steps it back one (first to aligned, second to first, third to second).
- R9: In the failure states, columns seen while expect_pos is low have no effect.
- R10: While col_aligned is 0, the output bus carries the local-fault sequence: byte 0x9C on lane 0, 0x00 on lanes 1 and 2, 0x01 on lane 3, and rx_ctrl_out = 4'b1111. While col_aligned is 1, the input bus passes through unchanged in the same cycle.
- R11: Lane k occupies bits [8k+7:8k] of the data buses and bit k of the control and lane-flag buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_acode | input | 4 | Per-lane alignment-character flag |
| expect_pos | input | 1 | Marks the expected alignment slot in the gap |
| rx_data_in | input | 32 | Deskewed receive data, one byte per lane |
| rx_ctrl_in | input | 4 | Per-lane control flags |
| col_aligned | output | 1 | Column alignment status |
| realign_en | output | 1 | Permits the lane buffers to realign |
| rx_data_out | output | 32 | Receive data after fault override |
| rx_ctrl_out | output | 4 | Control flags after fault override |

## Verification
The status change and the data-bus override switch fall in the same cycle. The bus stops carrying the fault sequence in the very cycle col_aligned rises out of the last detection state. The override comes back in the very cycle the third failure sends the machine to unaligned. The bench drives a fresh data and control pattern with every vector, including those two transition vectors. After each edge it compares the bus against either the pass-through pattern or the fault sequence, chosen by the status value it expects for that cycle. Any lag or lead between the two functions is therefore reported.

// File: rtl/col_deskew_pkg.sv
// Shared types and constants for the column alignment monitor.
// Assumes lane bytes are LANE_W bits wide, with 8 as the intended width.
package col_deskew_pkg;

    // Alignment state; ordering matters: all states at or above ST_ALIGN report aligned.
    typedef enum logic [2:0] {
        ST_UNALIGN = 3'd0,
        ST_DET1    = 3'd1,
        ST_DET2    = 3'd2,
        ST_DET3    = 3'd3,
        ST_ALIGN   = 3'd4,
        ST_FAIL1   = 3'd5,
        ST_FAIL2   = 3'd6,
        ST_FAIL3   = 3'd7
    } col_state_t;

    // Byte placed on lane 0 during the local-fault override (sequence control character).
    localparam logic [7:0] FAULT_SEQ_CHAR = 8'h9C;
    // Byte placed on the last lane during the override (local fault code).
    localparam logic [7:0] FAULT_LAST_BYTE = 8'h01;
    // Byte placed on the lanes in between.
    localparam logic [7:0] FAULT_MID_BYTE = 8'h00;

endpackage

// File: rtl/col_classify.sv
// Column classifier: reduces the per-lane alignment flags of one cycle
// to "complete" (every lane flagged) and "partial" (some, not all).
// Assumes the flags are already time-aligned by upstream deskew buffers.
module col_classify #(
    parameter int NUM_LANES = 4
) (
    input  logic [NUM_LANES-1:0] lane_flag,
    output logic                 complete,
    output logic                 partial
);

    // Purpose: derive the column class from the lane flags.
    always_comb begin
        complete = &lane_flag;
        partial  = (|lane_flag) && !(&lane_flag);
    end

endmodule

// File: rtl/col_align_fsm.sv
// Alignment state machine: acquisition through three detection states,
// then an aligned state guarded by three graded failure states that are
// evaluated only at the expected alignment slot of the gap.
// Assumes complete and partial are mutually exclusive.
module col_align_fsm
    import col_deskew_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       complete,
    input  logic       partial,
    input  logic       expect_pos,
    output col_state_t state,
    output logic       aligned,
    output logic       realign
);

    col_state_t nxt;

    // Purpose: compute the next state from the column class and slot marker.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_UNALIGN: if (complete) nxt = ST_DET1;
            ST_DET1: begin
                if (complete)     nxt = ST_DET2;
                else if (partial) nxt = ST_UNALIGN;
            end
            ST_DET2: begin
                if (complete)     nxt = ST_DET3;
                else if (partial) nxt = ST_UNALIGN;
            end
            ST_DET3: begin
                if (complete)     nxt = ST_ALIGN;
                else if (partial) nxt = ST_UNALIGN;
            end
            ST_ALIGN: if (expect_pos && partial) nxt = ST_FAIL1;
            ST_FAIL1: if (expect_pos) nxt = complete ? ST_ALIGN : ST_FAIL2;
            ST_FAIL2: if (expect_pos) nxt = complete ? ST_FAIL1 : ST_FAIL3;
            ST_FAIL3: if (expect_pos) nxt = complete ? ST_FAIL2 : ST_UNALIGN;
            default:  nxt = ST_UNALIGN;
        endcase
    end

    // Purpose: hold the state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_UNALIGN;
        else        state <= nxt;
    end

    // Purpose: decode the status and realignment strobe from the state.
    always_comb begin
        aligned = (state >= ST_ALIGN);
        realign = (state == ST_UNALIGN);
    end

    // R3
    rise_from_det3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(state) == ST_DET3);

    // R2
    leave_unalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state) == ST_UNALIGN && state != ST_UNALIGN) |-> state == ST_DET1);

    // R7
    align_to_fail1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN && expect_pos && partial) |=> state == ST_FAIL1);

    // R8
    fail3_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAIL3 && expect_pos && !complete) |=> state == ST_UNALIGN);

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state >= ST_FAIL1 && !expect_pos) |=> $stable(state));

    // R4
    det_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_DET1, ST_DET2, ST_DET3} && partial) |=> state == ST_UNALIGN);

endmodule

// File: rtl/rx_fault_mux.sv
// Receive bus override: while fault_en is high, every lane carries its
// byte of the local-fault sequence with its control flag set; otherwise
// the input bus passes through in the same cycle.
// Assumes LANE_W is at least 8.
module rx_fault_mux
    import col_deskew_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8,
    localparam int BUS_W    = NUM_LANES * LANE_W
) (
    input  logic                 fault_en,
    input  logic [BUS_W-1:0]     data_in,
    input  logic [NUM_LANES-1:0] ctrl_in,
    output logic [BUS_W-1:0]     data_out,
    output logic [NUM_LANES-1:0] ctrl_out
);

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [LANE_W-1:0] fault_byte;
        if (k == 0) begin : g_first
            assign fault_byte = LANE_W'(FAULT_SEQ_CHAR);
        end else if (k == NUM_LANES - 1) begin : g_last
            assign fault_byte = LANE_W'(FAULT_LAST_BYTE);
        end else begin : g_mid
            assign fault_byte = LANE_W'(FAULT_MID_BYTE);
        end

        // Purpose: select fault byte or incoming byte for lane k.
        always_comb begin
            data_out[k*LANE_W +: LANE_W] = fault_en ? fault_byte : data_in[k*LANE_W +: LANE_W];
            ctrl_out[k]                  = fault_en ? 1'b1 : ctrl_in[k];
        end
    end

    // R10
    always_comb begin
        if (fault_en) fault_ctrl_chk: assert (&ctrl_out);
    end

endmodule

// File: rtl/col_deskew_sm.sv
// Top of the column alignment monitor. Classifies each column of lane
// flags, runs the alignment state machine and overrides the receive bus
// with a local fault while the column is not aligned.
// Assumes inputs are synchronous to clk and already lane-deskewed.
module col_deskew_sm
    import col_deskew_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8,
    localparam int BUS_W    = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_acode,
    input  logic                 expect_pos,
    input  logic [BUS_W-1:0]     rx_data_in,
    input  logic [NUM_LANES-1:0] rx_ctrl_in,
    output logic                 col_aligned,
    output logic                 realign_en,
    output logic [BUS_W-1:0]     rx_data_out,
    output logic [NUM_LANES-1:0] rx_ctrl_out
);

    logic       col_complete;
    logic       col_partial;
    col_state_t align_state;

    col_classify #(.NUM_LANES(NUM_LANES)) u_classify (
        .lane_flag (lane_acode),
        .complete  (col_complete),
        .partial   (col_partial)
    );

    col_align_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .complete   (col_complete),
        .partial    (col_partial),
        .expect_pos (expect_pos),
        .state      (align_state),
        .aligned    (col_aligned),
        .realign    (realign_en)
    );

    rx_fault_mux #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_mux (
        .fault_en (!col_aligned),
        .data_in  (rx_data_in),
        .ctrl_in  (rx_ctrl_in),
        .data_out (rx_data_out),
        .ctrl_out (rx_ctrl_out)
    );

    // R6
    realign_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        realign_en |-> !col_aligned);

    // R5
    status_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_aligned |-> align_state >= ST_ALIGN);

endmodule

// File: tb/col_deskew_sm_test.sv
module col_deskew_sm_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lane_acode = '0;
    logic        expect_pos = 1'b0;
    logic [31:0] rx_data_in = '0;
    logic [3:0]  rx_ctrl_in = '0;
    logic        col_aligned, realign_en;
    logic [31:0] rx_data_out;
    logic [3:0]  rx_ctrl_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] LF_DATA = 32'h0100_009C;

    always #5 clk = ~clk;

    col_deskew_sm uut (
        .clk(clk), .rst_n(rst_n), .lane_acode(lane_acode), .expect_pos(expect_pos),
        .rx_data_in(rx_data_in), .rx_ctrl_in(rx_ctrl_in), .col_aligned(col_aligned),
        .realign_en(realign_en), .rx_data_out(rx_data_out), .rx_ctrl_out(rx_ctrl_out)
    );

    // Vector: {lane flags[3:0], expect_pos, expected col_aligned, expected realign_en}
    localparam int NV = 30;
    localparam logic [6:0] VEC [NV] = '{
        {4'b0000,1'b0,1'b0,1'b1}, // R2 hold
        {4'b0101,1'b0,1'b0,1'b1}, // R2 partial stays
        {4'b1111,1'b0,1'b0,1'b0}, // R2 -> DET1
        {4'b0000,1'b0,1'b0,1'b0}, // R3 hold
        {4'b1111,1'b0,1'b0,1'b0}, // DET2
        {4'b0011,1'b0,1'b0,1'b1}, // R4 -> UNALIGN
        {4'b1111,1'b0,1'b0,1'b0}, // DET1
        {4'b1111,1'b0,1'b0,1'b0}, // DET2
        {4'b1111,1'b0,1'b0,1'b0}, // DET3
        {4'b1000,1'b1,1'b0,1'b1}, // R4 -> UNALIGN
        {4'b1111,1'b0,1'b0,1'b0}, // DET1
        {4'b1111,1'b0,1'b0,1'b0}, // DET2
        {4'b1111,1'b0,1'b0,1'b0}, // DET3
        {4'b1111,1'b0,1'b1,1'b0}, // R3 -> ALIGN
        {4'b0110,1'b0,1'b1,1'b0}, // R7 off slot
        {4'b0000,1'b1,1'b1,1'b0}, // R7 empty
        {4'b1111,1'b1,1'b1,1'b0}, // R7 complete
        {4'b0110,1'b1,1'b1,1'b0}, // R7 -> FAIL1
        {4'b0000,1'b0,1'b1,1'b0}, // R9 ignored
        {4'b1111,1'b1,1'b1,1'b0}, // R8 -> ALIGN
        {4'b0001,1'b1,1'b1,1'b0}, // FAIL1
        {4'b0000,1'b1,1'b1,1'b0}, // R8 FAIL2
        {4'b1111,1'b0,1'b1,1'b0}, // R9 ignored
        {4'b1111,1'b1,1'b1,1'b0}, // R8 FAIL1
        {4'b0000,1'b1,1'b1,1'b0}, // FAIL2
        {4'b0010,1'b1,1'b1,1'b0}, // FAIL3
        {4'b1111,1'b1,1'b1,1'b0}, // R8 FAIL2
        {4'b0000,1'b1,1'b1,1'b0}, // FAIL3
        {4'b0000,1'b1,1'b0,1'b1}, // R8 -> UNALIGN
        {4'b1111,1'b1,1'b0,1'b0}  // R2 DET1
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Check status, strobe and bus against the expected status (R5 R6 R10 R11)
    task automatic check_out(input logic al, input logic re, input logic [31:0] d, input logic [3:0] c);
        check("R5 col_aligned", 64'(col_aligned), 64'(al));
        check("R6 realign_en", 64'(realign_en), 64'(re));
        check("R10 data", 64'(rx_data_out), al ? 64'(d) : 64'(LF_DATA));
        check("R10 ctrl", 64'(rx_ctrl_out), al ? 64'(c) : 64'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rx_data_in = 32'hDEAD_BEEF;
        #1;
        // R1 reset state
        check_out(1'b0, 1'b1, rx_data_in, rx_ctrl_in);

        for (int i = 0; i < NV; i++) begin
            lane_acode = VEC[i][6:3];
            expect_pos = VEC[i][2];
            rx_data_in = 32'h1000_0000 * (i % 16) + 32'h0123_4567 + i;
            rx_ctrl_in = 4'(i);
            @(posedge clk);
            @(negedge clk);
            check_out(VEC[i][1], VEC[i][0], rx_data_in, rx_ctrl_in);
        end

        // Reacquire, then R11 lane mapping with distinct bytes
        lane_acode = 4'b1111; expect_pos = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        lane_acode = 4'b0000;
        rx_data_in = 32'hA4B3_C2D1; rx_ctrl_in = 4'b0100;
        #1;
        check("R11 lane3 byte", 64'(rx_data_out[31:24]), 64'hA4);
        check("R11 lane0 byte", 64'(rx_data_out[7:0]), 64'hD1);
        check("R11 ctrl lane2", 64'(rx_ctrl_out), 64'h4);

        // R1 reset while aligned
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_out(1'b0, 1'b1, rx_data_in, rx_ctrl_in);
        rst_n = 1'b1;
        // R1 override lane bytes after reset
        check("R1 lane0 seq char", 64'(rx_data_out[7:0]), 64'h9C);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule